// File: doc/BRIEF.md
# General-Purpose I/O Port

A single general-purpose I/O port of parameterized width, controlled through a small synchronous register bus. Software selects a register with a 2-bit address. A write strobe stores the write data, and the read data returns one clock later from a register. Each pin has a per-pin direction bit and an output latch bit. The pin itself connects through a tri-state style pair (`pad_out_o`, `pad_oe_o`) and returns through `pad_in_i`.

There are three registers. Address 0 selects direction: a bit of 1 marks the pin as an input and a bit of 0 marks it as an output. Address 1 selects the port: a write to it updates the output latch, and a read returns the pin levels after a two-stage synchronizer. Address 2 selects the output latch: a read returns the stored value, whatever level the pins are at. A parameter mask lists the pins that exist. Bits of pins that do not exist ignore writes, read as zero, and never drive.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads the implemented-pin mask (every existing pin an input), the output latch reads 0, and `pad_oe_o` and `pad_out_o` are 0.
- R2: `pad_oe_o[i]` is 1 exactly when pin i exists and its direction bit is 0. It follows a direction write on the clock edge that stores it.
- R3: A read of the direction register (address 0) returns the last value written to it, masked to the existing pins.
- R4: A write to the port register (address 1) has the same effect on the output latch as a write to the latch register (address 2).
- R5: A read of the port register returns the pin levels through two flip-flops. A level applied before clock edge n appears in `rdata_o` after edge n+2.
- R6: A read of the latch register returns the stored latch value, independent of `pad_in_i`.
- R7: `pad_out_o` equals the output latch value for the existing pins.
- R8: Bits of pins that do not exist (mask bit 0) read as 0 from every register, ignore writes, and keep `pad_oe_o` and `pad_out_o` at 0. With the default mask of 8'h7F, bit 7 is such a pin.
- R9: Address 3 has no register. Reads from it return 0, and writes to it change nothing.
- R10: `rdata_o` is registered. After a clock edge it shows the register at the address presented before that edge, as it stood before that edge, so a read issued together with a write returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 direction, 1 port, 2 latch, 3 none |
| we_i | input | 1 | Write strobe |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Registered read data |
| pad_in_i | input | WIDTH | Raw pin levels |
| pad_out_o | output | WIDTH | Pin output values |
| pad_oe_o | output | WIDTH | Pin output enables |

## Verification
The hardest case is to tell the synchronized pin view apart from the latch. That needs pin levels that differ from the latch contents, changed on a known cycle while the port address is held. The stimulus then samples `rdata_o` on each following cycle to pin down the exact latency. A read is also issued in the same cycle as a write, to show that the registered read path returns the old value. Writes of all ones go to every address, so that the missing top pin and the empty address can be seen to stay at zero.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_PORT = 2'd1,
    ADDR_LAT  = 2'd2,
    ADDR_NONE = 2'd3
  } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  gpio_addr_e       addr_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] lat_o
);
  logic dir_we, lat_we;

  assign dir_we = we_i && (addr_i == ADDR_DIR);
  // port and latch addresses share one storage
  assign lat_we = we_i && (addr_i == ADDR_PORT || addr_i == ADDR_LAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= IMPL_MASK;
      lat_o <= '0;
    end else begin
      if (dir_we) dir_o <= wdata_i & IMPL_MASK;
      if (lat_we) lat_o <= wdata_i & IMPL_MASK;
    end
  end

  // R3
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_DIR) |=> dir_o == ($past(wdata_i) & IMPL_MASK));
  // R4
  port_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_PORT) |=> lat_o == ($past(wdata_i) & IMPL_MASK));
  // R9
  none_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_NONE) |=> ($stable(dir_o) && $stable(lat_o)));
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  gpio_addr_e       addr_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] lat_i,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] rd_d;

  always_comb begin
    unique case (addr_i)
      ADDR_DIR:  rd_d = dir_i;
      ADDR_PORT: rd_d = pins_i;
      ADDR_LAT:  rd_d = lat_i;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end

  // R6
  lat_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_LAT) |=> rdata_o == $past(lat_i));
  // R9
  none_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_NONE) |=> rdata_o == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = {1'b0, {(WIDTH-1){1'b1}}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  gpio_addr_e       addr;
  logic [WIDTH-1:0] dir_q, lat_q, sync_q;

  assign addr = gpio_addr_e'(addr_i);

  gpio_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk_i, .rst_ni, .addr_i(addr), .we_i, .wdata_i,
    .dir_o(dir_q), .lat_o(lat_q)
  );

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(sync_q)
  );

  gpio_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .clk_i, .rst_ni, .addr_i(addr), .dir_i(dir_q), .lat_i(lat_q),
    .pins_i(sync_q & IMPL_MASK), .rdata_o
  );

  // missing pins are forced to input
  assign pad_oe_o  = ~dir_q & IMPL_MASK;
  assign pad_out_o = lat_q;

  // R8
  impl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o | pad_out_o | rdata_o) & ~IMPL_MASK) == '0);
  // R2
  oe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> pad_oe_o == (~$past(wdata_i) & IMPL_MASK));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int         W = 8;
  localparam logic [7:0] M = 8'h7F;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] rdata, pad_out, pad_oe;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  string tag = "R10";

  always #2 clk = ~clk;

  gpio_port #(.WIDTH(W), .IMPL_MASK(M)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  // behavioural reference
  logic [W-1:0] m_dir, m_lat, m_s1, m_s2, m_rd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = M; m_lat = '0; m_s1 = '0; m_s2 = '0; m_rd = '0;
    end else begin
      case (addr)
        2'd0: m_rd = m_dir;
        2'd1: m_rd = m_s2 & M;
        2'd2: m_rd = m_lat;
        default: m_rd = '0;
      endcase
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (we && addr == 2'd0) m_dir = wdata & M;
      if (we && (addr == 2'd1 || addr == 2'd2)) m_lat = wdata & M;
    end
  end

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // per-cycle comparison with the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rdata, m_rd, {tag, " rdata"});
      chk(pad_oe, ~m_dir & M, "R2 pad_oe");
      chk(pad_out, m_lat, "R7 pad_out");
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] exp, input string t);
    addr = a; we = 1'b0;
    @(negedge clk);
    chk(rdata, exp, t);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata, '0, "R1 rdata in reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(pad_oe, '0, "R1 pad_oe");
    chk(pad_out, '0, "R1 pad_out");
    rd(2'd0, M, "R1 dir reset");
    rd(2'd2, '0, "R1 lat reset");

    // R2 / R3
    wr(2'd0, 8'h0F);
    chk(pad_oe, 8'hF0 & M, "R2 oe after dir write");
    rd(2'd0, 8'h0F, "R3 dir readback");
    wr(2'd0, 8'h00);
    chk(pad_oe, M, "R8 oe bit7 held low");
    rd(2'd0, 8'h00, "R3 dir zero");

    // R4: port alias
    wr(2'd1, 8'hA5);
    rd(2'd2, 8'h25, "R4 port write lands in latch");
    chk(pad_out, 8'h25, "R7 pad_out after port write");
    wr(2'd2, 8'h3C);
    rd(2'd2, 8'h3C, "R4 latch write");

    // R6: latch independent of pins
    pad_in = 8'hC3;
    repeat (4) @(negedge clk);
    rd(2'd2, 8'h3C, "R6 latch ignores pins");
    rd(2'd1, 8'h43, "R5 port sees pins");

    // R5 latency
    addr = 2'd1;
    @(negedge clk);
    pad_in = 8'h5A;
    @(negedge clk);
    chk(rdata, 8'h43, "R5 latency +1");
    @(negedge clk);
    chk(rdata, 8'h43, "R5 latency +2");
    @(negedge clk);
    chk(rdata, 8'h5A, "R5 latency +3");
    pad_in = 8'hFF;
    repeat (4) @(negedge clk);
    chk(rdata, 8'h7F, "R8 port bit7 zero");

    // R8
    wr(2'd2, 8'hFF);
    chk(pad_out, 8'h7F, "R8 pad_out bit7");
    rd(2'd2, 8'h7F, "R8 latch bit7");
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'h7F, "R8 dir bit7");

    // R9
    wr(2'd0, 8'h12);
    wr(2'd2, 8'h34);
    wr(2'd3, 8'hFF);
    rd(2'd3, 8'h00, "R9 empty address");
    rd(2'd0, 8'h12, "R9 dir untouched");
    rd(2'd2, 8'h34, "R9 latch untouched");

    // R10: read together with write
    addr = 2'd2; we = 1'b1; wdata = 8'h66;
    @(negedge clk);
    we = 1'b0;
    chk(rdata, 8'h34, "R10 old value on write");
    @(negedge clk);
    chk(rdata, 8'h66, "R10 new value next");

    // mixed traffic against the reference
    tag = "R10 mixed";
    for (int i = 0; i < 200; i++) begin
      addr = 2'(i * 7 + i / 5);
      we = (i % 3) == 0;
      wdata = 8'(i * 37 + 11);
      if (i % 4 == 1) pad_in = 8'(i * 53);
      @(negedge clk);
    end
    we = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule